// File: doc/BRIEF.md
# Iterative Circular CORDIC Rotator

This block computes plane rotations with one shared add/shift stage that is reused over several clock cycles. An `init` strobe captures a signed operand vector `(x_in, y_in)` and an angle `z_in`. The block then runs one micro-rotation per clock, feeding the x, y and z results back as the next operands. A final cycle removes the CORDIC gain with a short sum of signed power-of-two terms. It then pulses `done` and holds its results until the next operand set has been processed.

Two operations are supported. In rotate mode (`mode` = 0), the vector is turned by the angle and z is driven toward zero. In vectoring mode (`mode` = 1), the vector is turned onto the positive x axis and the angle swept is added into z. Angles are signed binary fractions of a half turn: the code 2^(W-1) stands for π, so with W = 16 the value 16384 is +90 degrees and -16384 is -90 degrees. The x and y paths carry two guard bits, so the unscaled growth of about 1.647 times cannot overflow. The outputs are one bit wider than the inputs, so a corrected magnitude of up to sqrt(2) times full scale still fits.

The sequencer has four states. IDLE waits. ITER performs one iteration per cycle. GAIN applies the correction and registers the results. DONE shows the one-cycle `done` pulse. The transitions are as follows. Any state goes to ITER when `init` is high (this is the load, which clears the iteration index). ITER stays in ITER until the last index and then moves to GAIN. GAIN always moves to DONE. DONE returns to IDLE.

Top module: `cordic_rotator`

## Requirements
- R1: During and directly after reset, `done` is 0 and `x_out`, `y_out` and `z_out` are all 0.
- R2: Rotate mode (`mode` = 0), |θ| ≤ 90° with θ = z_in·π/2^(W-1): `x_out` ≈ x·cosθ − y·sinθ and `y_out` ≈ x·sinθ + y·cosθ, each within 10 LSB. `z_out` is within 10 LSB of 0.
- R3: Vectoring mode (`mode` = 1) with x_in ≥ 0: `x_out` ≈ sqrt(x²+y²) and `y_out` ≈ 0, each within 10 LSB. `z_out` ≈ z_in + atan2(y_in, x_in)·2^(W-1)/π, within 10 LSB.
- R4: The angle code 2^(W-2) means +90° and −2^(W-2) means −90°. Rotating (1000, 0) by these codes yields about (0, 1000) and (0, −1000).
- R5: `done` is first high in the cycle after the (ITER+2)-th rising edge, counting the edge that samples `init` as the first. The iteration index never reaches ITER.
- R6: `done` stays high for exactly one cycle. The outputs change only in the cycle in which `done` is high, and they hold their values afterwards until the next result.
- R7: An `init` during a computation aborts it. The results then belong to the new operands, and the latency of R5 is counted from the new `init`.
- R8: Full-scale operands, such as x = y = 2^(W-1)−1 in either mode, give correct results with no overflow. The corrected magnitude, up to about 1.4142·2^(W-1), appears on the W+1-bit outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| init | input | 1 | Load the operands and start (or restart) a computation |
| mode | input | 1 | 0 = rotate, 1 = vectoring |
| x_in | input | W | Signed x operand |
| y_in | input | W | Signed y operand |
| z_in | input | W | Signed angle, 2^(W-1) = π |
| x_out | output | W+1 | Gain-corrected x result |
| y_out | output | W+1 | Gain-corrected y result |
| z_out | output | W | Final angle |
| done | output | 1 | One-cycle pulse when results are updated |

## Verification
Some rules are checked by assertions on every cycle. These are: the single-cycle `done` pulse, the outputs holding still outside that pulse, no `done` in the cycle after an `init`, the exact init-to-done distance measured by a counter, and the iteration index staying in range. Only the bench scenarios can show that the numbers are right: the rotation results, the vectoring magnitude and angle, the quarter-turn encoding, full-scale behaviour without overflow, and the restart producing results for the second operand set. The bench compares each of these against real-valued trigonometry within a small tolerance.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_GAIN = 2'd2,
        ST_DONE = 2'd3
    } cordic_state_t;

    // Gain compensation 1/1.64676 ~= 2^-1 + 2^-3 - 2^-6 - 2^-9 - 2^-13
    localparam int GAIN_TERMS = 5;
    localparam int GAIN_SHIFT [GAIN_TERMS] = '{1, 3, 6, 9, 13};
    localparam bit GAIN_NEG   [GAIN_TERMS] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1};

    // atan(2^-i)/pi scaled by 2^31; truncated to the data width by the caller
    function automatic logic [31:0] step_angle32(input int unsigned i);
        logic [31:0] r;
        case (i)
            0:  r = 32'd536870912;
            1:  r = 32'd316933406;
            2:  r = 32'd167458907;
            3:  r = 32'd85004756;
            4:  r = 32'd42667331;
            5:  r = 32'd21354465;
            6:  r = 32'd10679838;
            7:  r = 32'd5340197;
            8:  r = 32'd2670176;
            9:  r = 32'd1335090;
            10: r = 32'd667544;
            11: r = 32'd333772;
            12: r = 32'd166886;
            13: r = 32'd83443;
            14: r = 32'd41722;
            15: r = 32'd20861;
            default: r = 32'd20861 >> (i - 15);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cordic_addsub.sv
module cordic_addsub #(
    parameter int WD = 18
) (
    input  logic signed [WD-1:0] a,
    input  logic signed [WD-1:0] b,
    input  logic                 sub,
    output logic signed [WD-1:0] s
);
    logic [WD-1:0] b_x;
    logic [WD:0]   sum;

    always_comb begin
        b_x = b ^ {WD{sub}};
        sum = {1'b0, a} + {1'b0, b_x} + {{WD{1'b0}}, sub};
        s   = sum[WD-1:0];
    end
endmodule

// File: rtl/cordic_stage.sv
module cordic_stage #(
    parameter int W  = 16,
    parameter int XW = 18,
    parameter int IW = 4
) (
    input  logic                 mode,
    input  logic [IW-1:0]        idx,
    input  logic signed [XW-1:0] x_i,
    input  logic signed [XW-1:0] y_i,
    input  logic signed [W-1:0]  z_i,
    output logic signed [XW-1:0] x_n,
    output logic signed [XW-1:0] y_n,
    output logic signed [W-1:0]  z_n
);
    import cordic_pkg::*;

    localparam int ASH = 32 - W;

    logic                 d_pos;
    logic signed [XW-1:0] y_sh;
    logic signed [XW-1:0] x_sh;
    logic [31:0]          ang_full;
    logic signed [W-1:0]  ang;

    always_comb begin
        // rotate: d = sgn(z); vectoring: d = -sgn(y)
        if (mode) d_pos = y_i[XW-1];
        else      d_pos = ~z_i[W-1];
        y_sh     = y_i >>> idx;
        x_sh     = x_i >>> idx;
        ang_full = step_angle32(32'(idx)) >> ASH;
        ang      = ang_full[W-1:0];
    end

    cordic_addsub #(.WD(XW)) u_x (.a(x_i), .b(y_sh), .sub(d_pos),  .s(x_n));
    cordic_addsub #(.WD(XW)) u_y (.a(y_i), .b(x_sh), .sub(~d_pos), .s(y_n));
    cordic_addsub #(.WD(W))  u_z (.a(z_i), .b(ang),  .sub(d_pos),  .s(z_n));
endmodule

// File: rtl/cordic_gain.sv
module cordic_gain #(
    parameter int XW = 18,
    parameter int OW = 17
) (
    input  logic signed [XW-1:0] v,
    output logic signed [OW-1:0] r
);
    import cordic_pkg::*;

    logic signed [XW-1:0] acc [GAIN_TERMS+1];

    assign acc[0] = '0;

    for (genvar k = 0; k < GAIN_TERMS; k++) begin : g_term
        logic signed [XW-1:0] part;
        assign part = v >>> GAIN_SHIFT[k];
        cordic_addsub #(.WD(XW)) u_add (
            .a  (acc[k]),
            .b  (part),
            .sub(GAIN_NEG[k]),
            .s  (acc[k+1])
        );
    end

    assign r = acc[GAIN_TERMS][OW-1:0];
endmodule

// File: rtl/cordic_ctrl.sv
module cordic_ctrl #(
    parameter int ITER = 14,
    parameter int IW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    output logic          load,
    output logic          step_en,
    output logic          gain_en,
    output logic          done,
    output logic [IW-1:0] idx
);
    import cordic_pkg::*;

    localparam logic [IW-1:0] LAST = IW'(ITER - 1);

    cordic_state_t state, next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= next;
            if (init || next != ST_ITER) idx <= '0;
            else if (state == ST_ITER)   idx <= idx + 1'b1;
        end
    end

    always_comb begin
        next = state;
        if (init) begin
            next = ST_ITER;
        end else begin
            unique case (state)
                ST_IDLE: next = ST_IDLE;
                ST_ITER: next = (idx == LAST) ? ST_GAIN : ST_ITER;
                ST_GAIN: next = ST_DONE;
                ST_DONE: next = ST_IDLE;
                default: next = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        load    = init;
        step_en = 1'b0;
        gain_en = 1'b0;
        done    = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_ITER: step_en = ~init;
            ST_GAIN: gain_en = ~init;
            ST_DONE: done    = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/cordic_rotator.sv
module cordic_rotator #(
    parameter int W    = 16,
    parameter int ITER = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                init,
    input  logic                mode,
    input  logic signed [W-1:0] x_in,
    input  logic signed [W-1:0] y_in,
    input  logic signed [W-1:0] z_in,
    output logic signed [W:0]   x_out,
    output logic signed [W:0]   y_out,
    output logic signed [W-1:0] z_out,
    output logic                done
);
    localparam int XW = W + 2;
    localparam int OW = W + 1;
    localparam int IW = (ITER > 1) ? $clog2(ITER) : 1;

    logic                 load, step_en, gain_en;
    logic [IW-1:0]        step_idx;
    logic                 mode_r;
    logic signed [XW-1:0] x_r, y_r, x_n, y_n;
    logic signed [W-1:0]  z_r, z_n;
    logic signed [OW-1:0] x_c, y_c;

    cordic_ctrl #(.ITER(ITER), .IW(IW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .init(init),
        .load(load), .step_en(step_en), .gain_en(gain_en),
        .done(done), .idx(step_idx)
    );

    cordic_stage #(.W(W), .XW(XW), .IW(IW)) u_stage (
        .mode(mode_r), .idx(step_idx),
        .x_i(x_r), .y_i(y_r), .z_i(z_r),
        .x_n(x_n), .y_n(y_n), .z_n(z_n)
    );

    cordic_gain #(.XW(XW), .OW(OW)) u_gain_x (.v(x_r), .r(x_c));
    cordic_gain #(.XW(XW), .OW(OW)) u_gain_y (.v(y_r), .r(y_c));

    // feedback registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_r    <= '0;
            y_r    <= '0;
            z_r    <= '0;
            mode_r <= 1'b0;
        end else if (load) begin
            x_r    <= {{(XW-W){x_in[W-1]}}, x_in};
            y_r    <= {{(XW-W){y_in[W-1]}}, y_in};
            z_r    <= z_in;
            mode_r <= mode;
        end else if (step_en) begin
            x_r <= x_n;
            y_r <= y_n;
            z_r <= z_n;
        end
    end

    // result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_out <= '0;
            y_out <= '0;
            z_out <= '0;
        end else if (gain_en) begin
            x_out <= x_c;
            y_out <= y_c;
            z_out <= z_r;
        end
    end
endmodule

// File: rtl/cordic_rotator_chk.sv
module cordic_rotator_chk #(
    parameter int W    = 16,
    parameter int ITER = 14,
    parameter int IW   = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                init,
    input logic                done,
    input logic signed [W:0]   x_out,
    input logic signed [W:0]   y_out,
    input logic signed [W-1:0] z_out,
    input logic [IW-1:0]       step_idx
);
    localparam int CW = $clog2(ITER + 4) + 1;

    logic [CW-1:0] since_init;
    logic          armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_init <= '0;
            armed      <= 1'b0;
        end else if (init) begin
            since_init <= '0;
            armed      <= 1'b1;
        end else if (armed && since_init != {CW{1'b1}}) begin
            since_init <= since_init + 1'b1;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(x_out) && $stable(y_out) && $stable(z_out))); // R6
    AST_RESTART_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> !done); // R7
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (armed && since_init == CW'(ITER + 1))); // R5
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(step_idx) < ITER); // R5
endmodule

bind cordic_rotator cordic_rotator_chk #(.W(W), .ITER(ITER), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .init(init), .done(done),
    .x_out(x_out), .y_out(y_out), .z_out(z_out), .step_idx(step_idx)
);

// File: tb/cordic_rotator_test.sv
`timescale 1ns/100ps
module cordic_rotator_test;
    localparam int W    = 16;
    localparam int ITER = 14;
    localparam real PI  = 3.14159265358979;
    localparam real ASC = 32768.0;   // 2^(W-1)
    localparam real TOL = 10.0;

    logic clk = 1'b0, rst_n = 1'b0, init = 1'b0, mode = 1'b0;
    logic signed [W-1:0] x_in = '0, y_in = '0, z_in = '0;
    logic signed [W:0]   x_out, y_out;
    logic signed [W-1:0] z_out;
    logic                done;

    int checks = 0, failures = 0;
    int lat;

    always #2.5 clk = ~clk;

    cordic_rotator #(.W(W), .ITER(ITER)) uut (
        .clk(clk), .rst_n(rst_n), .init(init), .mode(mode),
        .x_in(x_in), .y_in(y_in), .z_in(z_in),
        .x_out(x_out), .y_out(y_out), .z_out(z_out), .done(done)
    );

    task automatic chk_int(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_near(string req, string what, int act, real exp);
        real d;
        checks++;
        d = real'(act) - exp;
        if (d < 0.0) d = -d;
        if (d > TOL) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0.2f", req, what, act, exp);
        end
    endtask

    // start an operation and return edges from init sample to visible done
    task automatic start_op(input logic m, input int xv, input int yv, input int zv);
        @(negedge clk);
        mode = m; x_in = W'(xv); y_in = W'(yv); z_in = W'(zv); init = 1'b1;
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        init = 1'b0;
    endtask

    task automatic wait_done();
        while (!done && lat < 100) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk_int("R1", "done in reset", int'(done), 0);
        chk_int("R1", "x_out in reset", int'(x_out), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk_int("R1", "y_out after reset", int'(y_out), 0);
        chk_int("R1", "z_out after reset", int'(z_out), 0);
        chk_int("R1", "done after reset", int'(done), 0);
    endtask

    task automatic t_rotate(string req, int xv, int yv, int zv);
        real th;
        th = real'(zv) * PI / ASC;
        start_op(1'b0, xv, yv, zv);
        wait_done();
        chk_int("R5", "latency rotate", lat, ITER + 2);
        chk_near(req, "rotate x", int'(x_out), real'(xv) * $cos(th) - real'(yv) * $sin(th));
        chk_near(req, "rotate y", int'(y_out), real'(xv) * $sin(th) + real'(yv) * $cos(th));
        chk_near(req, "rotate z", int'(z_out), 0.0);
    endtask

    task automatic t_vector(string req, int xv, int yv, int zv);
        start_op(1'b1, xv, yv, zv);
        wait_done();
        chk_int("R5", "latency vectoring", lat, ITER + 2);
        chk_near(req, "vector x", int'(x_out), $sqrt(real'(xv) * real'(xv) + real'(yv) * real'(yv)));
        chk_near(req, "vector y", int'(y_out), 0.0);
        chk_near(req, "vector z", int'(z_out), real'(zv) + $atan2(real'(yv), real'(xv)) * ASC / PI);
    endtask

    task automatic t_pulse_hold();
        int xs, ys, zs;
        t_rotate("R2", 12000, -7000, -6000);
        xs = int'(x_out); ys = int'(y_out); zs = int'(z_out);
        @(negedge clk);
        chk_int("R6", "done one cycle", int'(done), 0);
        x_in = 16'sd1; y_in = 16'sd2; z_in = 16'sd3;   // no init: ignored
        repeat (5) @(negedge clk);
        chk_int("R6", "x held", int'(x_out), xs);
        chk_int("R6", "y held", int'(y_out), ys);
        chk_int("R6", "z held", int'(z_out), zs);
        chk_int("R6", "done stays low", int'(done), 0);
    endtask

    task automatic t_abort();
        int xs;
        start_op(1'b0, 5000, 0, 8192);
        repeat (5) @(negedge clk);
        xs = int'(x_out);
        t_rotate("R7", -9000, 4000, 3000);
        chk_int("R7", "no early done", lat, ITER + 2);
        checks++;
        if (int'(x_out) == xs) begin
            failures++;
            $display("FAIL R7 restart x actual=%0d expected new result", int'(x_out));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_rotate("R2", -20000, 5000, 5461);
        t_rotate("R4", 1000, 0, 16384);
        t_rotate("R4", 1000, 0, -16384);
        t_vector("R3", 3000, -4000, 0);
        t_vector("R3", 20000, 0, 1000);
        t_vector("R3", 7000, 9000, -2000);
        t_rotate("R8", 32767, 32767, 8192);
        t_vector("R8", 32767, 32767, 0);
        t_vector("R8", 32767, -32767, 0);
        t_pulse_hold();
        t_abort();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule